// File: doc/BRIEF.md
# Profiled RAM Waveform Playback Controller

The block stores a 1024-word by 32-bit sample memory and streams a chosen slice of it to one control input of a downstream synthesizer. A timer reloaded from the active profile spaces the fetches, so the profile fixes the output sample rate. Each fetched word is routed to the amplitude, phase or frequency output, or split into a magnitude and a phase field for polar modulation.

Eight profile registers each hold a first address, a last address, a timer reload value and a destination code. A 3-bit select input picks the active profile. Playback starts from the selected profile's first address when the enable input is high and either the update strobe is sampled or the select input changes. It runs up to the last address, then stops with the outputs held and a done flag raised. A host write port loads the memory and the profiles. Memory writes are refused while playback runs.

Top module: `wave_player`

## Requirements
- R1: With `host_sel_i`=0, a host write stores `host_wdata_i` into sample word `host_addr_i` (1024 words of 32 bits).
- R2: With `host_sel_i`=1, `host_addr_i[2:0]` picks the profile. With `host_addr_i[3]`=0 the write sets first address from bits [9:0], last address from bits [19:10] and destination from bits [21:20]. With `host_addr_i[3]`=1 it sets the 16-bit timer reload from bits [15:0].
- R3: With `play_en_i` high, a clock edge that samples `update_i` high starts playback of the profile on `prof_i`, beginning at its first address.
- R4: With `play_en_i` high, a clock edge that samples `prof_i` different from the value it held at the previous edge starts playback of the new profile. This restarts the address and the timer even mid-run.
- R5: With `play_en_i` low, no playback starts and no samples are produced. Lowering it during playback halts fetching without raising `done_o`.
- R6: For a reload value R, the first sample's valid pulse is seen R+2 clock edges after the starting edge. Later samples follow every R+1 cycles.
- R7: Words from the first to the last address are played in ascending order, each exactly once. After the last one `done_o` is high, no further valid pulses occur and the outputs hold their values. `done_o` clears on the next start.
- R8: Destination code 0 sends word bits [31:18] to `amp_o`, code 1 sends bits [31:16] to `phase_o`, and code 2 sends the whole word to `freq_o`. Only the matching valid output pulses.
- R9: Destination code 3 (polar) sends bits [31:16] to `phase_o` and bits [15:2] to `amp_o`, with both valids pulsing in the same cycle. Bits [1:0] are ignored and `freq_vld_o` stays low.
- R10: A host memory write issued while playback is active leaves the memory unchanged.
- R11: After reset all outputs are zero, all valids are low and `done_o` is low.
- R12: If the last address is below the first, the address wraps from 1023 to 0 and continues to the last address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | 0 selects sample memory, 1 selects profile registers |
| host_addr_i | input | 10 | Word address or profile index and word select |
| host_wdata_i | input | 32 | Host write data |
| play_en_i | input | 1 | Playback enable level |
| update_i | input | 1 | Update strobe that starts playback |
| prof_i | input | 3 | Active profile select |
| amp_o | output | 14 | Amplitude sample |
| amp_vld_o | output | 1 | Amplitude sample valid pulse |
| phase_o | output | 16 | Phase sample |
| phase_vld_o | output | 1 | Phase sample valid pulse |
| freq_o | output | 32 | Frequency sample |
| freq_vld_o | output | 1 | Frequency sample valid pulse |
| done_o | output | 1 | Last address of the running profile has been played |

## Verification
Each table vector plays a distinct address slice with its own reload value and destination code. A swapped field, a wrong off-by-one address, a stale timer or a misrouted valid therefore shows up as a wrong word or a wrong pulse spacing. Reload zero and a single-word profile probe the tightest timer and end conditions, and a slice crossing address 1023 separates a wrapping counter from a saturating one. Directed runs switch the profile mid-play, drop the enable mid-play, and write memory during playback, which separates a real restart, a real halt and a real write lock from outputs that merely happen to match.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    DST_AMP   = 2'd0,
    DST_PHASE = 2'd1,
    DST_FREQ  = 2'd2,
    DST_POLAR = 2'd3
  } dest_e;
endpackage

// File: rtl/wp_sample_mem.sv
module wp_sample_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/wp_profile_regs.sv
module wp_profile_regs #(
  parameter int NUM_PROF = 8,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int TIMER_W  = 16,
  localparam int PROF_W  = $clog2(NUM_PROF),
  localparam int CFG_W   = 2 * ADDR_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PROF_W-1:0]  idx_i,
  input  logic               word_sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [PROF_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0]  first_o,
  output logic [ADDR_W-1:0]  last_o,
  output logic [TIMER_W-1:0] reload_o,
  output logic [1:0]         dest_o
);
  logic [CFG_W-1:0]   cfg_arr    [NUM_PROF];
  logic [TIMER_W-1:0] reload_arr [NUM_PROF];

  for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
    logic [CFG_W-1:0]   cfg_q;
    logic [TIMER_W-1:0] reload_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q    <= '0;
        reload_q <= '0;
      end else if (we_i && idx_i == PROF_W'(p)) begin
        if (!word_sel_i) cfg_q    <= wdata_i[CFG_W-1:0];
        else             reload_q <= wdata_i[TIMER_W-1:0];
      end
    end

    assign cfg_arr[p]    = cfg_q;
    assign reload_arr[p] = reload_q;
  end

  // field order of word 0: {dest, last, first}
  assign first_o  = cfg_arr[rd_idx_i][ADDR_W-1:0];
  assign last_o   = cfg_arr[rd_idx_i][2*ADDR_W-1:ADDR_W];
  assign dest_o   = cfg_arr[rd_idx_i][CFG_W-1:2*ADDR_W];
  assign reload_o = reload_arr[rd_idx_i];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:CFG_W];
endmodule

// File: rtl/wp_sequencer.sv
module wp_sequencer #(
  parameter int ADDR_W  = 10,
  parameter int TIMER_W = 16,
  parameter int PROF_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               update_i,
  input  logic [PROF_W-1:0]  prof_i,
  input  logic [ADDR_W-1:0]  first_i,
  input  logic [ADDR_W-1:0]  last_i,
  input  logic [TIMER_W-1:0] reload_i,
  input  logic [1:0]         dest_i,
  output logic               active_o,
  output logic               done_o,
  output logic               fetch_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [1:0]         dest_o
);
  logic [PROF_W-1:0]  prof_q;
  logic               active_q, done_q;
  logic [ADDR_W-1:0]  addr_q, last_q;
  logic [TIMER_W-1:0] timer_q, reload_q;
  logic [1:0]         dest_q;
  logic               start;

  assign start   = en_i && (update_i || prof_i != prof_q);
  assign fetch_o = active_q && en_i && !start && timer_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prof_q <= '0;
    else         prof_q <= prof_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      last_q   <= '0;
      timer_q  <= '0;
      reload_q <= '0;
      dest_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      done_q   <= 1'b0;
      addr_q   <= first_i;
      last_q   <= last_i;
      timer_q  <= reload_i;
      reload_q <= reload_i;
      dest_q   <= dest_i;
    end else if (!en_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (timer_q == '0) begin
        addr_q  <= addr_q + 1'b1;
        timer_q <= reload_q;
        if (addr_q == last_q) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end else begin
        timer_q <= timer_q - 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
  assign addr_o   = addr_q;
  assign dest_o   = dest_q;

  p_end_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o && addr_q == last_q) |=> (!active_q && done_q));
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !active_q);
  p_timer_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && en_i && !start && timer_q != '0) |=> timer_q == TIMER_W'($past(timer_q) - 1'b1));
  p_start_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (active_q && !done_q && addr_q == $past(first_i)));
  p_halt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_q);
endmodule

// File: rtl/wp_router.sv
module wp_router #(
  parameter int DATA_W  = 32,
  parameter int AMP_W   = 14,
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_i,
  input  logic [1:0]         dest_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [AMP_W-1:0]   amp_o,
  output logic               amp_vld_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               phase_vld_o,
  output logic [DATA_W-1:0]  freq_o,
  output logic               freq_vld_o
);
  import wp_pkg::*;

  localparam int MAG_TOP = DATA_W - PHASE_W - 1;

  logic  vld_q;
  dest_e dest_q;

  // data_i lands one cycle after the fetch; align the destination with it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      dest_q <= DST_AMP;
    end else begin
      vld_q  <= fetch_i;
      dest_q <= dest_e'(dest_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_o       <= '0;
      phase_o     <= '0;
      freq_o      <= '0;
      amp_vld_o   <= 1'b0;
      phase_vld_o <= 1'b0;
      freq_vld_o  <= 1'b0;
    end else begin
      amp_vld_o   <= 1'b0;
      phase_vld_o <= 1'b0;
      freq_vld_o  <= 1'b0;
      if (vld_q) begin
        unique case (dest_q)
          DST_AMP: begin
            amp_o     <= data_i[DATA_W-1 -: AMP_W];
            amp_vld_o <= 1'b1;
          end
          DST_PHASE: begin
            phase_o     <= data_i[DATA_W-1 -: PHASE_W];
            phase_vld_o <= 1'b1;
          end
          DST_FREQ: begin
            freq_o     <= data_i;
            freq_vld_o <= 1'b1;
          end
          DST_POLAR: begin
            phase_o     <= data_i[DATA_W-1 -: PHASE_W];
            amp_o       <= data_i[MAG_TOP -: AMP_W];
            phase_vld_o <= 1'b1;
            amp_vld_o   <= 1'b1;
          end
        endcase
      end
    end
  end

  p_freq_alone_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_vld_o |-> (!amp_vld_o && !phase_vld_o));
  p_polar_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_vld_o && phase_vld_o) |-> $past(dest_q) == DST_POLAR);
  p_pulse_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_vld_o || phase_vld_o || freq_vld_o) |-> $past(vld_q));
endmodule

// File: rtl/wave_player.sv
module wave_player #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int TIMER_W  = 16,
  parameter int NUM_PROF = 8,
  parameter int AMP_W    = 14,
  parameter int PHASE_W  = 16,
  localparam int PROF_W  = $clog2(NUM_PROF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic               host_sel_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  input  logic               play_en_i,
  input  logic               update_i,
  input  logic [PROF_W-1:0]  prof_i,
  output logic [AMP_W-1:0]   amp_o,
  output logic               amp_vld_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               phase_vld_o,
  output logic [DATA_W-1:0]  freq_o,
  output logic               freq_vld_o,
  output logic               done_o
);
  logic               active, fetch, mem_we, prof_we;
  logic [ADDR_W-1:0]  rd_addr, p_first, p_last;
  logic [TIMER_W-1:0] p_reload;
  logic [1:0]         p_dest, run_dest;
  logic [DATA_W-1:0]  rd_data;

  // memory is locked while a profile is playing
  assign mem_we  = host_we_i && !host_sel_i && !active;
  assign prof_we = host_we_i && host_sel_i;

  wp_sample_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (host_addr_i),
    .wdata_i (host_wdata_i),
    .re_i    (fetch),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  wp_profile_regs #(.NUM_PROF(NUM_PROF), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                    .TIMER_W(TIMER_W)) u_prof (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (prof_we),
    .idx_i      (host_addr_i[PROF_W-1:0]),
    .word_sel_i (host_addr_i[PROF_W]),
    .wdata_i    (host_wdata_i),
    .rd_idx_i   (prof_i),
    .first_o    (p_first),
    .last_o     (p_last),
    .reload_o   (p_reload),
    .dest_o     (p_dest)
  );

  wp_sequencer #(.ADDR_W(ADDR_W), .TIMER_W(TIMER_W), .PROF_W(PROF_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (play_en_i),
    .update_i (update_i),
    .prof_i   (prof_i),
    .first_i  (p_first),
    .last_i   (p_last),
    .reload_i (p_reload),
    .dest_i   (p_dest),
    .active_o (active),
    .done_o   (done_o),
    .fetch_o  (fetch),
    .addr_o   (rd_addr),
    .dest_o   (run_dest)
  );

  wp_router #(.DATA_W(DATA_W), .AMP_W(AMP_W), .PHASE_W(PHASE_W)) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_i     (fetch),
    .dest_i      (run_dest),
    .data_i      (rd_data),
    .amp_o       (amp_o),
    .amp_vld_o   (amp_vld_o),
    .phase_o     (phase_o),
    .phase_vld_o (phase_vld_o),
    .freq_o      (freq_o),
    .freq_vld_o  (freq_vld_o)
  );

  p_mem_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && host_we_i && !host_sel_i) |-> !u_mem.we_i);
  p_fetch_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch |-> (active && play_en_i));
endmodule

// File: tb/sim_wave_player.sv
module sim_wave_player;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_sel = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        play_en = 1'b0, upd = 1'b0;
  logic [2:0]  prof = '0;
  logic [13:0] amp;
  logic [15:0] phase;
  logic [31:0] freq;
  logic        amp_vld, phase_vld, freq_vld, done;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wave_player u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_sel_i(host_sel),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .play_en_i(play_en),
    .update_i(upd), .prof_i(prof), .amp_o(amp), .amp_vld_o(amp_vld),
    .phase_o(phase), .phase_vld_o(phase_vld), .freq_o(freq),
    .freq_vld_o(freq_vld), .done_o(done)
  );

  // {first, last, reload, dest}
  localparam int NV = 6;
  localparam logic [37:0] VECS [NV] = '{
    {10'd0,    10'd3,    16'd2, 2'd0},
    {10'd10,   10'd14,   16'd0, 2'd1},
    {10'd100,  10'd102,  16'd5, 2'd2},
    {10'd500,  10'd504,  16'd1, 2'd3},
    {10'd1022, 10'd1,    16'd3, 2'd2},
    {10'd1023, 10'd1023, 16'd4, 2'd3}
  };

  function automatic logic [31:0] wexp(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(bit sel, logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_prof(int k, logic [9:0] f, logic [9:0] l, logic [15:0] r, logic [1:0] d);
    host_wr(1'b1, 10'(k), {10'd0, d, l, f});
    host_wr(1'b1, 10'(k) | 10'h8, {16'd0, r});
  endtask

  // observe n samples from word f on, timed from start edge following cycle t0
  task automatic collect(int t0, int f, int n, int r, int d, string tag);
    int got = 0, prev = 0;
    logic [31:0] w;
    for (int c = 0; c < 4000 && got < n; c++) begin
      @(negedge clk);
      if (amp_vld || phase_vld || freq_vld) begin
        w = wexp((f + got) % 1024);
        chk(cyc == ((got == 0) ? t0 + r + 3 : prev + r + 1), "R6 spacing", cyc, (got == 0) ? t0 + r + 3 : prev + r + 1);
        case (d)
          0: chk(amp_vld && !phase_vld && !freq_vld && amp == w[31:18], {tag, " R8 amp"}, amp, w[31:18]);
          1: chk(phase_vld && !amp_vld && !freq_vld && phase == w[31:16], {tag, " R8 phase"}, phase, w[31:16]);
          2: chk(freq_vld && !amp_vld && !phase_vld && freq == w, {tag, " R8 freq"}, freq, w);
          default: chk(amp_vld && phase_vld && !freq_vld && amp == w[15:2] && phase == w[31:16],
                       {tag, " R9 polar"}, {phase, 2'b0, amp}, {w[31:16], 2'b0, w[15:2]});
        endcase
        prev = cyc;
        got++;
      end
    end
    chk(got == n, {tag, " R7 count"}, got, n);
  endtask

  task automatic quiet_check(int cycles, string tag);
    logic [61:0] snap = {amp, phase, freq};
    int extra = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (amp_vld || phase_vld || freq_vld) extra++;
    end
    chk(extra == 0, {tag, " no pulses"}, extra, 0);
    chk({amp, phase, freq} == snap, {tag, " outputs hold"}, {amp, phase, freq} != snap, 0);
  endtask

  task automatic start_play(int k, output int t0);
    play_en = 1'b0; prof = 3'(k);
    repeat (2) @(negedge clk);
    play_en = 1'b1;
    @(negedge clk);
    upd = 1'b1; t0 = cyc;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(amp == 0 && phase == 0 && freq == 0, "R11 outputs zero", {amp, phase} | freq, 0);
    chk(!amp_vld && !phase_vld && !freq_vld && !done, "R11 flags low",
        {amp_vld, phase_vld, freq_vld, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 memory load
    for (int a = 0; a < 1024; a++) host_wr(1'b0, 10'(a), wexp(a));

    // table: R2 R3 R6 R7 R8 R9 R12
    for (int v = 0; v < NV; v++) begin
      logic [9:0] f = VECS[v][37:28], l = VECS[v][27:18];
      int r = int'(VECS[v][17:2]);
      int d = int'(VECS[v][1:0]);
      int n = ((int'(l) - int'(f) + 1024) % 1024) + 1;
      set_prof(v, f, l, 16'(r), 2'(d));
      start_play(v, t0);
      collect(t0, int'(f), n, r, d, (v == 4) ? "R12 wrap" : "R3");
      chk(done, "R7 done set", done, 1);
      quiet_check(r + 8, "R7 after end");
    end

    // R5: enable low blocks start
    play_en = 1'b0;
    @(negedge clk); upd = 1'b1; @(negedge clk); upd = 1'b0;
    quiet_check(30, "R5 disabled");
    chk(done, "R5 done untouched", done, 1);

    // R5: drop enable mid-run
    set_prof(6, 10'd200, 10'd260, 16'd3, 2'd2);
    start_play(6, t0);
    collect(t0, 200, 3, 3, 2, "R5 pre-halt");
    play_en = 1'b0;
    repeat (3) @(negedge clk);
    quiet_check(40, "R5 halted");
    chk(!done, "R5 halt not done", done, 0);

    // R4: profile change restarts mid-run
    set_prof(6, 10'd200, 10'd260, 16'd150, 2'd2);
    set_prof(7, 10'd300, 10'd302, 16'd2, 2'd1);
    start_play(6, t0);
    repeat (4) @(negedge clk);
    prof = 3'd7; t0 = cyc;
    collect(t0, 300, 3, 2, 1, "R4 switch");
    chk(done, "R4 done after new profile", done, 1);

    // R10: writes during playback are refused
    set_prof(5, 10'd400, 10'd403, 16'd20, 2'd2);
    start_play(5, t0);
    host_wr(1'b0, 10'd402, 32'hDEADBEEF);
    collect(t0, 400, 4, 20, 2, "R10 locked");
    // and accepted once idle (R1)
    host_wr(1'b0, 10'd402, wexp(402));
    start_play(5, t0);
    collect(t0, 400, 4, 20, 2, "R1 rewrite");

    finish_run();
  end
endmodule